// File: doc/BRIEF.md
# Register-File LIFO Stack with Full/Empty Flags

This block is a last-in, first-out store of 64 words held in registers, addressed by a 6-bit stack pointer that counts modulo 64. A push advances the pointer and then writes the input word at the new location. A pop reads the word at the current location into a registered output word and then moves the pointer back by one. Two status flags, full and empty, come from checking whether the pointer lands on zero after an operation.

Since the pointer starts at zero and advances before it writes, the first push goes to location 1. Location 0 is written only by the 64th push, which wraps the pointer back to zero and raises full. Requests that would overrun or underrun the stack are refused and reported with a one-cycle pulse. A push and a pop requested in the same cycle are also refused, and they raise a separate pulse. The data width is a parameter with a default of 8 bits.

Top module: `regstack`

## Requirements
- R1: While reset is held and in the first cycle after it is released, full = 0, empty = 1 and every pulse output is 0.
- R2: A push accepted when full = 0 (push_req = 1, pop_req = 0) clears empty one cycle later. It sets full only if this push is the 64th live word, that is, when the pointer wraps to zero.
- R3: A push request while full = 1 is refused and leaves the stored words and the flags unchanged. One cycle later ovf_pulse is high for exactly one cycle.
- R4: An accepted pop (pop_req = 1, push_req = 0, empty = 0) loads pop_data with the most recently pushed word that has not yet been popped, one cycle after the request.
- R5: A pop request while empty = 1 is refused. One cycle later udf_pulse is high for exactly one cycle, and pop_data and the flags are unchanged.
- R6: If push_req and pop_req are both 1 in a cycle, neither is performed. One cycle later err_pulse is high for exactly one cycle, while ovf_pulse and udf_pulse stay 0.
- R7: An accepted pop clears full. It sets empty only when the pop removes the last live word.
- R8: pop_data keeps its value until the next accepted pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_req | input | 1 | Request to push push_data |
| pop_req | input | 1 | Request to pop the top word |
| push_data | input | DW | Word to push |
| pop_data | output | DW | Registered word from the last accepted pop |
| full | output | 1 | Stack holds 64 words |
| empty | output | 1 | Stack holds no words |
| ovf_pulse | output | 1 | One-cycle pulse: push refused because the stack was full |
| udf_pulse | output | 1 | One-cycle pulse: pop refused because the stack was empty |
| err_pulse | output | 1 | One-cycle pulse: push and pop requested together |

## Verification
A pointer that is off by one would not show up right away. It appears at the first pop that follows, as a wrong word on pop_data one cycle after the request, or at a fill to 64 as a flag that rises one push too early or too late. A bad write into storage stays hidden until that location is popped, so the bench fills the stack completely and then drains it, comparing every popped word. The same full drain exposes any word that a refused push or a conflicting request damaged.

// File: rtl/regstack.sv
module regstack #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic [DW-1:0] push_data,
  output logic [DW-1:0] pop_data,
  output logic          full,
  output logic          empty,
  output logic          ovf_pulse,
  output logic          udf_pulse,
  output logic          err_pulse
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] sp;

  wire           both    = push_req & pop_req;
  wire           do_push = push_req & ~pop_req & ~full;
  wire           do_pop  = pop_req & ~push_req & ~empty;
  wire  [AW-1:0] sp_inc  = sp + 1'b1;
  wire  [AW-1:0] sp_dec  = sp - 1'b1;

  always_ff @(posedge clk)
    if (do_push) mem[sp_inc] <= push_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp        <= '0;
      full      <= 1'b0;
      empty     <= 1'b1;
      pop_data  <= '0;
      ovf_pulse <= 1'b0;
      udf_pulse <= 1'b0;
      err_pulse <= 1'b0;
    end else begin
      ovf_pulse <= push_req & ~pop_req & full;
      udf_pulse <= pop_req & ~push_req & empty;
      err_pulse <= both;
      if (do_push) begin
        sp    <= sp_inc;
        full  <= (sp_inc == '0);
        empty <= 1'b0;
      end else if (do_pop) begin
        pop_data <= mem[sp];
        sp       <= sp_dec;
        empty    <= (sp_dec == '0);
        full     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/regstack_chk.sv
module regstack_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_req,
  input logic          pop_req,
  input logic [DW-1:0] pop_data,
  input logic          full,
  input logic          empty,
  input logic          ovf_pulse,
  input logic          udf_pulse,
  input logic          err_pulse
);
  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));

  a_r2_push_clears_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && !full) |=> !empty);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !pop_req && full) |=> (ovf_pulse && full && $stable(pop_data)));

  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && empty) |=> (udf_pulse && empty && $stable(pop_data)));

  a_r6_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req) |=> (err_pulse && $stable(full) && $stable(empty) && $stable(pop_data)));

  a_r6_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_pulse, udf_pulse, err_pulse}));

  a_r7_pop_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !push_req && !empty) |=> !full);

  a_r8_hold_data: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop_req && !push_req && !empty) |=> $stable(pop_data));
endmodule

bind regstack regstack_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
  .pop_data(pop_data), .full(full), .empty(empty),
  .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .err_pulse(err_pulse)
);

// File: tb/regstack_tb.sv
module regstack_tb;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          push_req = 1'b0, pop_req = 1'b0;
  logic [DW-1:0] push_data = '0;
  logic [DW-1:0] pop_data;
  logic          full, empty, ovf_pulse, udf_pulse, err_pulse;

  int total = 0, bad = 0;
  bit done = 0;

  logic [DW-1:0] model [$];
  logic [DW-1:0] exp_q [$];
  logic [DW-1:0] last_dr = '0;
  bit e_ovf, e_udf, e_err;

  always #2 clk = ~clk;

  regstack #(.DW(DW), .AW(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .push_req(push_req), .pop_req(pop_req),
    .push_data(push_data), .pop_data(pop_data), .full(full), .empty(empty),
    .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse), .err_pulse(err_pulse)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compares popped words against the scoreboard queue
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n && pop_req && !push_req && exp_q.size() != 0) begin
        logic [DW-1:0] v;
        v = exp_q.pop_front();
        @(negedge clk);
        chk("R4 popped word", pop_data, v);
      end
    end
  end

  // Driver: one operation per cycle, called at a falling edge
  task automatic op(bit pu, bit po, logic [DW-1:0] d);
    bit f0, e0;
    f0 = (model.size() == 64);
    e0 = (model.size() == 0);
    push_req = pu; pop_req = po; push_data = d;
    e_ovf = pu && !po && f0;
    e_udf = po && !pu && e0;
    e_err = pu && po;
    if (pu && !po && !f0) model.push_back(d);
    if (po && !pu && !e0) begin
      last_dr = model.pop_back();
      exp_q.push_back(last_dr);
    end
    @(negedge clk);
    push_req = 0; pop_req = 0;
    chk("R2/R7 full flag", full, model.size() == 64);
    chk("R2/R7 empty flag", empty, model.size() == 0);
    chk("R3 overflow pulse", ovf_pulse, e_ovf);
    chk("R5 underflow pulse", udf_pulse, e_udf);
    chk("R6 conflict pulse", err_pulse, e_err);
    if (!(po && !pu && !e0)) chk("R8 data held", pop_data, last_dr);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset full", full, 0);
    chk("R1 reset empty", empty, 1);
    chk("R1 reset pulses", {ovf_pulse, udf_pulse, err_pulse}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release empty", empty, 1);
    chk("R1 after release full", full, 0);
    // R5: pop while empty
    op(0, 1, 0);
    op(0, 0, 0);
    // R2/R4: short push/pop
    op(1, 0, 8'h11); op(1, 0, 8'h22); op(1, 0, 8'h33);
    op(0, 1, 0); op(0, 1, 0); op(0, 1, 0);
    op(0, 1, 0);
    // R6: conflict with data present
    op(1, 0, 8'h5A);
    op(1, 1, 8'hEE);
    op(0, 1, 0);
    // R3: fill to 64, overflow, then full drain
    for (int i = 0; i < 64; i++) op(1, 0, 8'(i * 7 + 3));
    op(1, 0, 8'hFF);
    op(1, 1, 8'hAB);
    for (int i = 0; i < 64; i++) op(0, 1, 0);
    op(0, 1, 0);
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 9);
      op(r < 5 || r == 9, r >= 5, 8'($urandom));
    end
    while (model.size() != 0) op(0, 1, 0);
    op(0, 0, 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule